// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the external side of a memory controller whose address and data share one 24-bit bidirectional bus. An internal client hands it one access at a time: a base address, a read or write flag and a burst length. The block opens each access with an address phase, in which an address-latch strobe is high and the bus carries the base address for outside logic to latch when the strobe falls. It then runs one data phase per beat. In a write beat it drives the next write word from a valid/ready stream. In a read beat it leaves the bus undriven, captures the returned word on the edge that closes the beat and hands it back with a valid strobe.

Three low-order address pins are kept apart from the shared bus. They carry the start offset during the address phase and advance by one, modulo 8, on every beat, so a burst addresses successive columns while the latched base address on the bus stays fixed. The tri-state pad is modelled as an output enable, an output value and an input value.

Back-pressure rules: a request is taken only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while no access is open. A write beat completes only in a cycle where `wr_valid` and `wr_ready` are both high; while `wr_valid` is low the beat, the offset pins and the bus enable all wait. Read data has no back-pressure: the client must take every `rd_valid` word.

Top module: `mbm_bus_master`

## Requirements
- R1: After reset `req_ready` is 1 and `ale`, `bus_oe`, `wr_ready`, `rd_valid` and `done` are all 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high; `req_ready` stays 0 from the cycle after acceptance until the access has finished.
- R3: The address phase begins the cycle after acceptance and keeps `ale` high for `cfg_ale_cycles` cycles, with a value of 0 treated as 1; throughout it `bus_oe` is 1 and `bus_out` holds the full 24-bit request address unchanged.
- R4: In a write data phase `wr_ready` is 1, `bus_oe` equals `wr_valid`, `bus_out` equals `wr_data`, and a beat completes only on an edge where `wr_valid` is high, so write words appear on the bus in stream order.
- R5: After the final write beat `bus_oe` returns to 0.
- R6: In a read data phase `bus_oe` is 0; `bus_in` is sampled on the edge that ends each beat and presented on `rd_data` with `rd_valid` high for exactly one cycle per beat, in the following cycle.
- R7: `low_addr` equals bits 2:0 of the request address during the address phase and equals that start offset plus the beat index, modulo 8, during each data beat.
- R8: `req_burst` selects the beat count: code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8.
- R9: `done` is high for one cycle, in the cycle after the final beat; for a read it coincides with the last `rd_valid`, and for a write `req_ready` is already 1 in that cycle so the next request can be accepted there.
- R10: After a read, `req_ready` is still 0 in the `done` cycle, so at least one idle cycle with the bus undriven separates the last read beat from the next address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ale_cycles | input | 3 | Address-phase length in cycles, 0 means 1; sampled at acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 24 | Access base address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_burst | input | 2 | Burst code: 0,1,2,3 for 1,2,4,8 beats |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write data phase open |
| wr_data | input | 24 | Write word |
| rd_valid | output | 1 | Read word strobe, one per beat |
| rd_data | output | 24 | Captured read word |
| done | output | 1 | One-cycle pulse after the final beat |
| ale | output | 1 | Address-latch strobe |
| bus_oe | output | 1 | Shared-bus output enable |
| bus_out | output | 24 | Value driven on the shared bus |
| bus_in | input | 24 | Value seen on the shared bus |
| low_addr | output | 3 | Dedicated low address pins / burst column offset |

## Verification
Two events meet in one cycle at the end of every access: the completion pulse and either the last read strobe or the acceptance of the next request. The bench offers a new request in the very cycle it sees `done` after a write and checks that it is taken there, with the address strobe rising one cycle later; after a read it checks that `done` and the final `rd_valid` share a cycle while `req_ready` is still low. Throttled write streams and a burst starting at offset 6 show that the beat, the wrapping offset pins and the bus enable all move only on completed beats.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_TURN = 2'd3
  } bus_state_e;
endpackage

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
  import mbm_pkg::*;
#(
  parameter int LOW_W = 3,
  parameter int ALE_W = 3,
  localparam int BL_W = $clog2(LOW_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             req_write,
  input  logic [BL_W-1:0]  req_burst,
  input  logic [ALE_W-1:0] cfg_ale,
  input  logic             wr_valid,
  output bus_state_e       state,
  output logic             is_wr,
  output logic             beat_fire,
  output logic             last_beat,
  output logic             done
);
  logic [ALE_W-1:0] ale_left;
  logic [LOW_W-1:0] beats_left;
  logic [LOW_W-1:0] beats_init;
  logic [ALE_W-1:0] ale_init;

  // beat count minus one: 2**code - 1
  assign beats_init = LOW_W'(({{LOW_W{1'b0}}, 1'b1} << req_burst) - 1'b1);
  assign ale_init   = (cfg_ale == '0) ? '0 : cfg_ale - ALE_W'(1);
  assign beat_fire  = (state == ST_DATA) && (!is_wr || wr_valid);
  assign last_beat  = (beats_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ale_left   <= '0;
      beats_left <= '0;
      is_wr      <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= beat_fire && last_beat;
      unique case (state)
        ST_IDLE: if (req_fire) begin
          state      <= ST_ADDR;
          ale_left   <= ale_init;
          beats_left <= beats_init;
          is_wr      <= req_write;
        end
        ST_ADDR: begin
          if (ale_left == '0) state <= ST_DATA;
          else                ale_left <= ale_left - ALE_W'(1);
        end
        ST_DATA: if (beat_fire) begin
          if (last_beat) state <= is_wr ? ST_IDLE : ST_TURN;
          else           beats_left <= beats_left - LOW_W'(1);
        end
        ST_TURN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbm_offset.sv
module mbm_offset #(
  parameter int LOW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LOW_W-1:0] load_val,
  input  logic             step,
  output logic [LOW_W-1:0] offset
);
  // column offset, wraps naturally at 2**LOW_W
  always_ff @(posedge clk) begin
    if (!rst_n)    offset <= '0;
    else if (load) offset <= load_val;
    else if (step) offset <= offset + LOW_W'(1);
  end
endmodule

// File: rtl/mbm_rdcap.sv
module mbm_rdcap #(
  parameter int BUS_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [BUS_W-1:0] bus_in,
  output logic             rd_valid,
  output logic [BUS_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= bus_in;
    end
  end
endmodule

// File: rtl/mbm_bus_master.sv
module mbm_bus_master
  import mbm_pkg::*;
#(
  parameter int BUS_W = 24,
  parameter int LOW_W = 3,
  parameter int ALE_W = 3,
  localparam int BL_W = $clog2(LOW_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ALE_W-1:0] cfg_ale_cycles,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_addr,
  input  logic             req_write,
  input  logic [BL_W-1:0]  req_burst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [BUS_W-1:0] wr_data,
  output logic             rd_valid,
  output logic [BUS_W-1:0] rd_data,
  output logic             done,
  output logic             ale,
  output logic             bus_oe,
  output logic [BUS_W-1:0] bus_out,
  input  logic [BUS_W-1:0] bus_in,
  output logic [LOW_W-1:0] low_addr
);
  bus_state_e       state;
  logic             is_wr;
  logic             beat_fire;
  logic             last_beat;
  logic             req_fire;
  logic             rd_phase;
  logic [BUS_W-1:0] base_addr;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        base_addr <= '0;
    else if (req_fire) base_addr <= req_addr;
  end

  mbm_ctrl #(.LOW_W(LOW_W), .ALE_W(ALE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .req_write (req_write),
    .req_burst (req_burst),
    .cfg_ale   (cfg_ale_cycles),
    .wr_valid  (wr_valid),
    .state     (state),
    .is_wr     (is_wr),
    .beat_fire (beat_fire),
    .last_beat (last_beat),
    .done      (done)
  );

  mbm_offset #(.LOW_W(LOW_W)) u_offset (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req_fire),
    .load_val (req_addr[LOW_W-1:0]),
    .step     (beat_fire && !last_beat),
    .offset   (low_addr)
  );

  mbm_rdcap #(.BUS_W(BUS_W)) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (beat_fire && !is_wr),
    .bus_in   (bus_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign ale      = (state == ST_ADDR);
  assign wr_ready = (state == ST_DATA) && is_wr;
  assign rd_phase = (state == ST_DATA) && !is_wr;

  always_comb begin
    bus_oe  = 1'b0;
    bus_out = '0;
    if (ale) begin
      bus_oe  = 1'b1;
      bus_out = base_addr;
    end else if (wr_ready) begin
      bus_oe  = wr_valid;
      bus_out = wr_data;
    end
  end
endmodule

// File: rtl/mbm_chk.sv
module mbm_chk #(
  parameter int BUS_W = 24,
  parameter int LOW_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             ale,
  input logic             bus_oe,
  input logic [BUS_W-1:0] bus_out,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             done,
  input logic             rd_phase,
  input logic [LOW_W-1:0] low_addr
);
  a_r2_busy_while_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !req_ready);
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |-> ($stable(bus_out) && bus_oe));
  a_r7_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |-> $stable(low_addr));
  a_r4_drive_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && wr_valid) |-> bus_oe);
  a_r6_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !bus_oe);
  a_r10_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |=> !ale);
  a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_released_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_oe);
endmodule

bind mbm_bus_master mbm_chk #(.BUS_W(BUS_W), .LOW_W(LOW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ale       (ale),
  .bus_oe    (bus_oe),
  .bus_out   (bus_out),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .done      (done),
  .rd_phase  (rd_phase),
  .low_addr  (low_addr)
);

// File: tb/sim_mbm_bus_master.sv
module sim_mbm_bus_master;
  typedef struct packed {
    logic [23:0] addr;
    logic        wr;
    logic [1:0]  burst;
    logic [2:0]  alec;
    logic        stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{24'h012345, 1'b0, 2'd0, 3'd1, 1'b0},
    '{24'hABCDE6, 1'b1, 2'd3, 3'd2, 1'b0},
    '{24'h000007, 1'b0, 2'd1, 3'd0, 1'b0},
    '{24'h7FFFF2, 1'b1, 2'd2, 3'd1, 1'b1},
    '{24'h5A5A5E, 1'b0, 2'd3, 3'd3, 1'b0},
    '{24'hFEDCB9, 1'b1, 2'd1, 3'd7, 1'b1},
    '{24'h100003, 1'b0, 2'd2, 3'd1, 1'b0},
    '{24'h3C3C3B, 1'b1, 2'd0, 3'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_ale_cycles = 3'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_burst = '0;
  logic        wr_valid;
  logic        wr_ready;
  logic [23:0] wr_data;
  logic        rd_valid;
  logic [23:0] rd_data;
  logic        done;
  logic        ale;
  logic        bus_oe;
  logic [23:0] bus_out;
  logic [23:0] bus_in;
  logic [2:0]  low_addr;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  // bench-side monitors
  logic        clr = 1'b0;
  logic        stall_en = 1'b0;
  logic        stall_tog = 1'b0;
  logic [23:0] wbase = '0;
  logic [23:0] mem_lat = '0;
  int          ale_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [23:0] rd_buf [8];
  logic [23:0] wr_buf [8];
  logic [2:0]  wr_low [8];

  always #4 clk = ~clk;

  mbm_bus_master u0 (.*);

  function automatic logic [23:0] mem_word(input logic [20:0] hi, input logic [2:0] lo);
    return ({hi, lo} * 24'd7) ^ 24'h3C3C3C;
  endfunction

  assign bus_in   = mem_word(mem_lat[23:3], low_addr);
  assign wr_data  = wbase + 24'(wr_cnt);
  assign wr_valid = stall_en ? stall_tog : 1'b1;

  always @(negedge clk) stall_tog <= ~stall_tog;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      ale_cnt <= 0; rd_cnt <= 0; wr_cnt <= 0;
    end else begin
      if (ale) begin ale_cnt <= ale_cnt + 1; mem_lat <= bus_out; end
      if (rd_valid && rd_cnt < 8) begin rd_buf[rd_cnt] <= rd_data; rd_cnt <= rd_cnt + 1; end
      if (wr_valid && wr_ready && wr_cnt < 8) begin
        wr_buf[wr_cnt] <= bus_out; wr_low[wr_cnt] <= low_addr; wr_cnt <= wr_cnt + 1;
      end
    end
  end

  always @(posedge clk) if (cyc > 100000) begin
    nfail = nfail + 1;
    $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns the negedges spent waiting for ready
  task automatic start(input vec_t v, input int tag, output int waited);
    clr = 1'b1;
    wbase = 24'(tag) << 16;
    stall_en = v.stall;
    cfg_ale_cycles = v.alec;
    req_addr = v.addr; req_write = v.wr; req_burst = v.burst;
    req_valid = 1'b1;
    waited = 0;
    while (!req_ready) begin @(negedge clk); waited++; end
    @(negedge clk);
    clr = 1'b0;
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready low after accept", 32'(req_ready), 0);
    chk(ale, "R3", "strobe after accept", 32'(ale), 1);
    chk(low_addr == v.addr[2:0], "R7", "offset in address phase", 32'(low_addr), 32'(v.addr[2:0]));
  endtask

  // returns at the negedge of the done cycle (writes) or one later (reads)
  task automatic finish(input vec_t v, input int tag);
    int n = 1 << v.burst;  // R8 beat count
    int exp_ale = (v.alec == 0) ? 1 : int'(v.alec);
    while (!done) @(negedge clk);
    chk(!bus_oe, "R5", "bus released at done", 32'(bus_oe), 0);
    chk(ale_cnt == exp_ale, "R3", "strobe length", 32'(ale_cnt), 32'(exp_ale));
    chk(mem_lat == v.addr, "R3", "latched address", 32'(mem_lat), 32'(v.addr));
    if (v.wr) begin
      chk(req_ready, "R9", "ready in write done cycle", 32'(req_ready), 1);
      chk(wr_cnt == n, "R8", "write beat count", 32'(wr_cnt), 32'(n));
      for (int i = 0; i < n && i < 8; i++) begin
        chk(wr_buf[i] == wbase + 24'(i), "R4", "write word order", 32'(wr_buf[i]), 32'(wbase + 24'(i)));
        chk(wr_low[i] == 3'(v.addr[2:0] + 3'(i)), "R7", "write offset", 32'(wr_low[i]),
            32'(3'(v.addr[2:0] + 3'(i))));
      end
    end else begin
      chk(rd_valid, "R9", "done with last read strobe", 32'(rd_valid), 1);
      chk(!req_ready, "R10", "turnaround busy at done", 32'(req_ready), 0);
      @(negedge clk);
      chk(!done, "R9", "done one cycle", 32'(done), 0);
      chk(rd_cnt == n, "R6", "read strobe count", 32'(rd_cnt), 32'(n));
      for (int i = 0; i < n && i < 8; i++) begin
        logic [23:0] e = mem_word(v.addr[23:3], 3'(v.addr[2:0] + 3'(i)));
        chk(rd_buf[i] == e, "R6", "read word (R7 offset)", 32'(rd_buf[i]), 32'(e));
      end
    end
  endtask

  initial begin
    int w;
    vec_t vw, vr;
    repeat (3) @(negedge clk);
    // R1 reset state, sampled before release
    chk(req_ready && !ale && !bus_oe && !wr_ready && !rd_valid && !done, "R1", "reset outputs",
        {26'd0, req_ready, ale, bus_oe, wr_ready, rd_valid, done}, 32'h20);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_oe, "R1", "idle after reset", {30'd0, req_ready, bus_oe}, 2);

    for (int k = 0; k < NV; k++) begin
      start(VEC[k], k + 1, w);
      finish(VEC[k], k + 1);
      if (VEC[k].wr) @(negedge clk);
    end

    // R9: write done and next acceptance in the same cycle
    vw = '{24'h2468AE, 1'b1, 2'd2, 3'd1, 1'b1};
    vr = '{24'h13579D, 1'b0, 2'd3, 3'd2, 1'b0};
    start(vw, 9, w);
    finish(vw, 9);
    start(vr, 10, w);
    chk(w == 0, "R9", "accepted in done cycle", 32'(w), 0);
    finish(vr, 10);
    // R10: read followed directly by a write
    start(vw, 11, w);
    finish(vw, 11);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule